// File: doc/BRIEF.md
# Converter Start-Up and Auto-Restart Supervisor

This block sequences an off-line switching converter through its life cycle. It charges the supply capacitor from the high-voltage start-up source and then starts switching under a soft-start current-limit ramp. It runs in normal operation, stops on protection events, and performs a slow auto-restart after faults. Every input is a digitized comparator flag or a fault latch that has already been qualified. The outputs drive the start-up current source enable, the reduced-current select for that source, the switching enable and an 8-bit current-limit code that the current comparator decodes.

A start attempt begins when the supply reaches its turn-on threshold. The current-limit code then steps up from zero by one every `STEP_CYCLES` clocks until it reaches full scale. With the default of 3333 clocks per step and a 100 MHz clock, the ramp lasts about 8.5 ms. After an overload, over-voltage or over-current fault, the block does not recharge until the supply has decayed below the low restart threshold. It then recharges with the reduced current, so that retries after a fault are widely spaced. Brown-out and over-temperature only pause switching and do not latch anything.

Top module: `startup_supervisor`

## Requirements
- R1: `hv_charge_en` is high only while the block is charging, `drain_ok` is high and `vdd_on` is low. It is high in that case right after reset.
- R2: While charging, if `vdd_on` is high, `br_ok` is high and `over_temp` is low, then one clock later `sw_en` is 1, `hv_charge_en` is 0 and `ilim_code` is 0.
- R3: During soft-start, `ilim_code` equals floor(n / `STEP_CYCLES`) n clocks after switching begins. It stops at 255, which it reaches after 255·`STEP_CYCLES` clocks. The code never decreases while `sw_en` stays high.
- R4: After soft-start the block runs with `ilim_code` = 255, and `vdd_on` going low has no effect. `ilim_code` is 0 whenever `sw_en` is 0.
- R5: While switching, `vdd_above_off` low sets `sw_en` to 0 one clock later, without setting `low_charge_sel`. `hv_charge_en` then stays 0 while `vdd_above_rst` is high.
- R6: After switching has stopped, charging resumes only once `vdd_above_rst` is low, and only while `drain_ok` is high.
- R7: While switching, `fb_overload`, `ovp_fault` or `ocp_fault` high sets `sw_en` to 0 and `low_charge_sel` to 1 one clock later. The block then waits for the supply to fall below the restart threshold.
- R8: `low_charge_sel` stays 1 through the recharge and the soft-start of the next attempt, which again ramps from 0. It returns to 0 on the clock where the ramp completes and running begins.
- R9: Low `br_ok` while switching stops switching without setting `low_charge_sel`. If `br_ok` returns high while `vdd_above_off` is still high, switching resumes with a fresh ramp from 0.
- R10: High `over_temp` while switching behaves like a brown-out. Switching resumes only once `over_temp` is low again.
- R11: A fault and a brown-out in the same clock are treated as a fault: `low_charge_sel` is set, and `br_ok` recovering does not resume switching.
- R12: Turn-on is withheld while `br_ok` is low, with charging also off. When the supply then falls below the off threshold, charging resumes without waiting for the restart threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_on | input | 1 | Supply at or above turn-on threshold |
| vdd_above_off | input | 1 | Supply above undervoltage-off threshold |
| vdd_above_rst | input | 1 | Supply above restart threshold |
| drain_ok | input | 1 | Drain voltage above start level |
| fb_overload | input | 1 | Feedback above overload level |
| br_ok | input | 1 | Input line above brown-out level (with hysteresis) |
| over_temp | input | 1 | Over-temperature flag (with hysteresis) |
| ovp_fault | input | 1 | Qualified over-voltage fault latch |
| ocp_fault | input | 1 | Qualified over-current fault latch |
| hv_charge_en | output | 1 | Enable for the high-voltage start-up current source |
| low_charge_sel | output | 1 | Selects the reduced start-up current |
| sw_en | output | 1 | Switching enable; low holds the gate off |
| ilim_code | output | CODE_W | Current-limit code, ramped during soft-start |

## Verification
The bench uses a short step interval and compares every clock of each soft-start ramp against floor(n/step). A counter that is off by one, fails to saturate, or does not restart from zero after a pause or a fault shows up at an exact cycle. The bench drives undervoltage, brown-out and each fault source in turn from the running state. A design that recharged above the restart threshold, or that marked an undervoltage stop as a fault, would show the wrong `hv_charge_en` or `low_charge_sel` at the ports. A fault raised together with a brown-out, followed by brown-out recovery, catches a design that resumes switching after a fault. The bench also blocks turn-on with a brown-out to confirm that the supply falling below the off threshold, not the restart threshold, re-enables charging.

// File: rtl/startup_supervisor.sv
module startup_supervisor #(
  parameter int CODE_W      = 8,
  parameter int STEP_CYCLES = 3333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vdd_on,
  input  logic              vdd_above_off,
  input  logic              vdd_above_rst,
  input  logic              drain_ok,
  input  logic              fb_overload,
  input  logic              br_ok,
  input  logic              over_temp,
  input  logic              ovp_fault,
  input  logic              ocp_fault,
  output logic              hv_charge_en,
  output logic              low_charge_sel,
  output logic              sw_en,
  output logic [CODE_W-1:0] ilim_code
);
  localparam int TICK_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(STEP_CYCLES - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  typedef enum logic [2:0] {ST_CHARGE, ST_SOFT, ST_RUN, ST_HOLD, ST_DRAIN} st_t;

  st_t st, st_nx;
  logic post_fault;
  logic [TICK_W-1:0] tick;
  logic [CODE_W-1:0] code;

  wire fault     = fb_overload | ovp_fault | ocp_fault;
  wire inhibit   = ~br_ok | over_temp;
  wire switching = (st == ST_SOFT) || (st == ST_RUN);
  wire nx_sw     = (st_nx == ST_SOFT) || (st_nx == ST_RUN);

  always_comb begin
    st_nx = st;
    case (st)
      ST_CHARGE: if (vdd_on) st_nx = inhibit ? ST_HOLD : ST_SOFT;
      ST_SOFT, ST_RUN: begin
        if (fault || !vdd_above_off) st_nx = ST_DRAIN;
        else if (inhibit)            st_nx = ST_HOLD;
        else if (st == ST_SOFT && code == CODE_MAX) st_nx = ST_RUN;
      end
      ST_HOLD: begin
        if (!vdd_above_off) st_nx = ST_CHARGE;
        else if (!inhibit)  st_nx = ST_SOFT;
      end
      ST_DRAIN: if (!vdd_above_rst) st_nx = ST_CHARGE;
      default: st_nx = ST_CHARGE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_CHARGE;
      post_fault <= 1'b0;
    end else begin
      st <= st_nx;
      if (switching && fault)                       post_fault <= 1'b1;
      else if (st == ST_SOFT && st_nx == ST_RUN)    post_fault <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      tick <= '0;
    end else if (!nx_sw) begin
      code <= '0;
      tick <= '0;
    end else if (st == ST_SOFT) begin
      if (code != CODE_MAX) begin
        if (tick == TICK_LAST) begin
          tick <= '0;
          code <= code + 1'b1;
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end else if (st != ST_RUN) begin
      code <= '0;
      tick <= '0;
    end
  end

  assign hv_charge_en   = (st == ST_CHARGE) && drain_ok && !vdd_on;
  assign low_charge_sel = post_fault;
  assign sw_en          = switching;
  assign ilim_code      = code;
endmodule

module startup_supervisor_chk #(parameter int CODE_W = 8) (
  input logic              clk,
  input logic              rst_n,
  input logic              vdd_on,
  input logic              vdd_above_off,
  input logic              drain_ok,
  input logic              fb_overload,
  input logic              ovp_fault,
  input logic              ocp_fault,
  input logic              hv_charge_en,
  input logic              low_charge_sel,
  input logic              sw_en,
  input logic [CODE_W-1:0] ilim_code
);
  assert_charge_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hv_charge_en |-> (drain_ok && !vdd_on && !sw_en));

  assert_ramp_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(sw_en)) |-> (ilim_code >= $past(ilim_code)));

  assert_code_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> (ilim_code == '0));

  assert_uvlo_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !vdd_above_off) |=> !sw_en);

  assert_fault_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && (fb_overload || ovp_fault || ocp_fault)) |=> (!sw_en && low_charge_sel));
endmodule

bind startup_supervisor startup_supervisor_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/startup_supervisor_test.sv
`timescale 1ns/1ps
module startup_supervisor_test;
  localparam int STEP = 3;
  localparam int CMAX = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vdd_on = 0, vdd_above_off = 0, vdd_above_rst = 0, drain_ok = 0;
  logic fb_overload = 0, br_ok = 0, over_temp = 0, ovp_fault = 0, ocp_fault = 0;
  logic hv_charge_en, low_charge_sel, sw_en;
  logic [7:0] ilim_code;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  startup_supervisor #(.CODE_W(8), .STEP_CYCLES(STEP)) uut (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ramp(input int exp_low);
    for (int n = 0; n <= CMAX * STEP; n++) begin
      int e = n / STEP;
      if (e > CMAX) e = CMAX;
      chk(ilim_code, e, "R3 ramp code");
      chk(sw_en, 1, "R3 switching during ramp");
      chk(low_charge_sel, exp_low, "R8 select held during ramp");
      tick(1);
    end
    chk(low_charge_sel, 0, "R8 select cleared at run");
    chk(ilim_code, CMAX, "R4 full scale at run");
  endtask

  task automatic supply_up();
    vdd_above_rst = 1; vdd_above_off = 1; vdd_on = 1;
    tick(1);
    chk(sw_en, 1, "R2 switching on");
    chk(hv_charge_en, 0, "R2 charger off");
    chk(ilim_code, 0, "R2 ramp from zero");
  endtask

  task automatic to_restart(input int exp_low);
    vdd_on = 0; vdd_above_off = 0; vdd_above_rst = 0;
    tick(1);
    chk(hv_charge_en, 1, "R6 charging below restart");
    chk(low_charge_sel, exp_low, "R8 reduced current select");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk(sw_en, 0, "reset sw_en");
    chk(hv_charge_en, 0, "reset hv_charge_en");
    chk(low_charge_sel, 0, "reset low_charge_sel");
    chk(ilim_code, 0, "reset ilim_code");
    rst_n = 1;
    tick(1);
    chk(hv_charge_en, 0, "R1 no drain no charge");
    drain_ok = 1; br_ok = 1;
    tick(1);
    chk(hv_charge_en, 1, "R1 charging");
    chk(low_charge_sel, 0, "R1 full current at first start");

    supply_up();
    ramp(0);
    vdd_on = 0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      chk(sw_en, 1, "R4 run ignores vdd_on");
      chk(ilim_code, CMAX, "R4 code held");
    end

    vdd_above_off = 0;
    tick(1);
    chk(sw_en, 0, "R5 uvlo stop");
    chk(ilim_code, 0, "R4 code zero when stopped");
    chk(low_charge_sel, 0, "R5 no fault mark");
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk(hv_charge_en, 0, "R5 no charge above restart");
    end
    vdd_above_rst = 0;
    tick(1);
    chk(hv_charge_en, 1, "R6 charge below restart");
    drain_ok = 0;
    tick(1);
    chk(hv_charge_en, 0, "R6 drain low inhibits charge");
    drain_ok = 1;
    tick(1);
    supply_up();
    ramp(0);

    for (int k = 0; k < 3; k++) begin
      fb_overload = (k == 0); ovp_fault = (k == 1); ocp_fault = (k == 2);
      tick(1);
      chk(sw_en, 0, "R7 fault stop");
      chk(low_charge_sel, 1, "R7 fault marks restart");
      fb_overload = 0; ovp_fault = 0; ocp_fault = 0;
      tick(3);
      chk(hv_charge_en, 0, "R7 waits for restart level");
      chk(sw_en, 0, "R7 stays off");
      vdd_on = 0; vdd_above_off = 0;
      tick(2);
      chk(hv_charge_en, 0, "R7 waits below off");
      to_restart(1);
      supply_up();
      ramp(1);
    end

    br_ok = 0;
    tick(1);
    chk(sw_en, 0, "R9 brown-out stop");
    chk(low_charge_sel, 0, "R9 no fault mark");
    tick(3);
    chk(hv_charge_en, 0, "R9 no charge in hold");
    br_ok = 1;
    tick(1);
    chk(sw_en, 1, "R9 resume");
    chk(ilim_code, 0, "R9 fresh ramp");
    ramp(0);

    over_temp = 1;
    tick(1);
    chk(sw_en, 0, "R10 thermal stop");
    tick(4);
    chk(sw_en, 0, "R10 held while hot");
    chk(low_charge_sel, 0, "R10 no fault mark");
    over_temp = 0;
    tick(1);
    chk(sw_en, 1, "R10 resume");
    ramp(0);

    br_ok = 0; ocp_fault = 1;
    tick(1);
    chk(sw_en, 0, "R11 stop");
    chk(low_charge_sel, 1, "R11 fault wins");
    br_ok = 1; ocp_fault = 0;
    tick(2);
    chk(sw_en, 0, "R11 no resume on brown-out recovery");
    to_restart(1);
    supply_up();
    ramp(1);

    vdd_above_off = 0;
    tick(1);
    to_restart(0);
    br_ok = 0;
    vdd_above_rst = 1; vdd_above_off = 1; vdd_on = 1;
    tick(1);
    chk(sw_en, 0, "R12 turn-on withheld");
    chk(hv_charge_en, 0, "R12 no charge while withheld");
    vdd_on = 0; vdd_above_off = 0;
    tick(1);
    chk(hv_charge_en, 1, "R12 charge resumes below off");
    br_ok = 1;
    supply_up();
    ramp(0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule